// File: doc/BRIEF.md
# HDLC Shared-Line Access Arbiter

This block decides when an HDLC station may start transmitting on a shared open-drain serial line, and when it has lost the line to another station. It sits between a bit-stream framer and the line driver. The framer raises a frame request and offers one serial bit at a time. The arbiter places each bit on its transmit output and reads the resolved line level back through an echo input. On the line a zero from any station beats a one.

Access is granted by counting consecutive idle ones seen on the line. A station in the normal, high-priority state may begin after 8 such ones. Once a frame has gone out cleanly, the station drops to low priority and must see 10 ones before its next attempt. This gives a waiting peer the chance to take the line first. A station that drives a one but reads back a zero has lost arbitration. It releases the line at once, tells the framer, and returns to high priority.

Bit timing comes from an oversampling enable with four ticks per bit. The transmit bit changes on tick 0. The line is sampled on tick 2 by default, or on tick 3 when late sampling is selected. Late sampling suits a clock whose low phase is longer than its high phase.

Top module: `hdlc_bus_arbiter`

## Requirements
- R1: While reset is held and in the cycle after, txd is 1 and bit_ready, frame_done and frame_collided are 0.
- R2: In high priority, a requested frame starts on the first tick 0 after 8 consecutive ones have been sampled on cts. From reset on an idle line this is bit 8, where bits are numbered from the first tick_en after reset.
- R3: After frame_done the station is in low priority. Its next frame starts only after 10 consecutive ones, sampled from the bit that follows the last frame bit.
- R4: A zero sampled on cts while the station is not transmitting clears the idle count. A zero sampled in bit z on an otherwise idle line moves the first start to bit z+9.
- R5: The idle count saturates. A request raised after any length of idle line starts on the next tick 0.
- R6: cts is sampled on tick 2 of each bit when sample_late is 0, and on tick 3 when sample_late is 1. A zero present on the other tick has no effect.
- R7: Each frame bit is held on txd for one bit period from tick 0. bit_ready pulses for one cycle each time a bit is taken. The bit taken while last_bit is 1 ends the frame, and frame_done pulses for one cycle at the next tick 0.
- R8: If txd is 1 and cts is 0 at the sample tick, frame_collided pulses for one cycle. txd then stays 1 until a new frame starts, and that attempt produces no frame_done.
- R9: After a collision, from either priority, the next attempt waits for only 8 ones.
- R10: A zero read on cts while txd is 0 is not a collision, and the frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Oversampling enable, four per bit |
| sample_late | input | 1 | 0: sample on tick 2, 1: sample on tick 3 |
| frame_req | input | 1 | Framer has a frame to send |
| tx_bit | input | 1 | Next serial bit from the framer |
| last_bit | input | 1 | tx_bit is the final bit of the frame |
| cts | input | 1 | Resolved line level read back |
| txd | output | 1 | Open-drain transmit level (1 = released) |
| bit_ready | output | 1 | Bit taken; framer presents the next one |
| frame_done | output | 1 | Frame finished without collision |
| frame_collided | output | 1 | Arbitration lost; frame abandoned |

## Verification
The bench builds the block with its default parameters: 4 ticks per bit, thresholds of 8 and 10, and therefore a 4-bit idle counter. Both sampling modes are swept. The sweeps cover frame lengths 1 to 6, a line zero in each of bits 0 to 7, and a zero on a single tick. The single-tick zero tells tick 2 from tick 3. A collision is placed in every bit position of a 6-bit frame, in the first frame and in the second. Idle gaps of 20 and 37 bits go past 16, so a counter that wrapped instead of saturating would withhold the start.

// File: rtl/hbarb_pkg.sv
package hbarb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_t;
endpackage

// File: rtl/hbarb_bit_timer.sv
module hbarb_bit_timer #(
  parameter int TICKS_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic sample_late,
  output logic boundary_evt,
  output logic sample_evt
);
  localparam int PH_W     = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int MID_TICK = TICKS_PER_BIT / 2;
  localparam int LATE_TICK = (3 * TICKS_PER_BIT) / 4;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_BIT - 1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] sample_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (tick_en) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  always_comb begin
    sample_ph    = sample_late ? PH_W'(LATE_TICK) : PH_W'(MID_TICK);
    boundary_evt = tick_en && (phase_q == '0);
    sample_evt   = tick_en && (phase_q == sample_ph);
  end

  // R6: bit boundary and sample point never coincide
  p_evt_apart_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({boundary_evt, sample_evt}));
endmodule

// File: rtl/hbarb_idle_mon.sv
module hbarb_idle_mon #(
  parameter int HI_PRI_ONES = 8,
  parameter int LO_PRI_ONES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_evt,
  input  logic line_bit,
  input  logic tx_active,
  input  logic frame_ok,
  input  logic frame_lost,
  output logic ready,
  output logic lo_pri,
  output logic [$clog2(LO_PRI_ONES+1)-1:0] idle_cnt
);
  localparam int CNT_W = $clog2(LO_PRI_ONES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LO_PRI_ONES);
  localparam logic [CNT_W-1:0] THR_HI  = CNT_W'(HI_PRI_ONES);
  localparam logic [CNT_W-1:0] THR_LO  = CNT_W'(LO_PRI_ONES);

  logic [CNT_W-1:0] cnt_q;
  logic             lo_q;
  logic [CNT_W-1:0] thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tx_active) begin
      cnt_q <= '0;
    end else if (sample_evt) begin
      if (!line_bit) begin
        cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= 1'b0;
    end else if (frame_ok) begin
      lo_q <= 1'b1;
    end else if (frame_lost) begin
      lo_q <= 1'b0;
    end
  end

  always_comb begin
    thr      = lo_q ? THR_LO : THR_HI;
    ready    = (cnt_q >= thr);
    lo_pri   = lo_q;
    idle_cnt = cnt_q;
  end

  // R5: count never passes the low-priority threshold
  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);

  // R4: a sampled zero while idle leaves the count empty
  p_zero_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_evt && !line_bit) |=> (cnt_q == '0));
endmodule

// File: rtl/hbarb_tx_ctrl.sv
module hbarb_tx_ctrl
  import hbarb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic boundary_evt,
  input  logic sample_evt,
  input  logic line_bit,
  input  logic ready,
  input  logic frame_req,
  input  logic tx_bit,
  input  logic last_bit,
  output logic txd,
  output logic bit_ready,
  output logic done,
  output logic collided,
  output logic tx_active,
  output logic frame_ok,
  output logic frame_lost
);
  tx_state_t state_q;
  logic txd_q, last_q, rdy_q, done_q, coll_q;
  logic evt_start, evt_next, evt_end, evt_coll;

  always_comb begin
    evt_start = (state_q == ST_IDLE) && boundary_evt && frame_req && ready;
    evt_coll  = (state_q == ST_SEND) && sample_evt && txd_q && !line_bit;
    evt_end   = (state_q == ST_SEND) && boundary_evt && last_q;
    evt_next  = (state_q == ST_SEND) && boundary_evt && !last_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      txd_q   <= 1'b1;
      last_q  <= 1'b0;
      rdy_q   <= 1'b0;
      done_q  <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      rdy_q  <= evt_start || evt_next;
      done_q <= evt_end;
      coll_q <= evt_coll;
      if (evt_start) begin
        state_q <= ST_SEND;
        txd_q   <= tx_bit;
        last_q  <= last_bit;
      end else if (evt_coll || evt_end) begin
        state_q <= ST_IDLE;
        txd_q   <= 1'b1;
        last_q  <= 1'b0;
      end else if (evt_next) begin
        txd_q  <= tx_bit;
        last_q <= last_bit;
      end
    end
  end

  always_comb begin
    txd        = txd_q;
    bit_ready  = rdy_q;
    done       = done_q;
    collided   = coll_q;
    tx_active  = (state_q == ST_SEND);
    frame_ok   = evt_end;
    frame_lost = evt_coll;
  end

  // R8: success and loss never reported together
  p_done_coll_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done_q && coll_q));

  // R8: line released in the cycle a loss is reported
  p_release_on_loss_r8: assert property (@(posedge clk) disable iff (rst)
    coll_q |-> (txd_q && state_q == ST_IDLE));
endmodule

// File: rtl/hdlc_bus_arbiter.sv
module hdlc_bus_arbiter #(
  parameter int TICKS_PER_BIT = 4,
  parameter int HI_PRI_ONES   = 8,
  parameter int LO_PRI_ONES   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic sample_late,
  input  logic frame_req,
  input  logic tx_bit,
  input  logic last_bit,
  input  logic cts,
  output logic txd,
  output logic bit_ready,
  output logic frame_done,
  output logic frame_collided
);
  localparam int CNT_W = $clog2(LO_PRI_ONES + 1);

  logic boundary_evt, sample_evt;
  logic ready, lo_pri, tx_active, frame_ok, frame_lost;
  logic [CNT_W-1:0] idle_cnt;

  hbarb_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .sample_late  (sample_late),
    .boundary_evt (boundary_evt),
    .sample_evt   (sample_evt)
  );

  hbarb_idle_mon #(
    .HI_PRI_ONES (HI_PRI_ONES),
    .LO_PRI_ONES (LO_PRI_ONES)
  ) u_idle (
    .clk        (clk),
    .rst        (rst),
    .sample_evt (sample_evt),
    .line_bit   (cts),
    .tx_active  (tx_active),
    .frame_ok   (frame_ok),
    .frame_lost (frame_lost),
    .ready      (ready),
    .lo_pri     (lo_pri),
    .idle_cnt   (idle_cnt)
  );

  hbarb_tx_ctrl u_tx (
    .clk          (clk),
    .rst          (rst),
    .boundary_evt (boundary_evt),
    .sample_evt   (sample_evt),
    .line_bit     (cts),
    .ready        (ready),
    .frame_req    (frame_req),
    .tx_bit       (tx_bit),
    .last_bit     (last_bit),
    .txd          (txd),
    .bit_ready    (bit_ready),
    .done         (frame_done),
    .collided     (frame_collided),
    .tx_active    (tx_active),
    .frame_ok     (frame_ok),
    .frame_lost   (frame_lost)
  );

  // R2: a frame only starts when the idle monitor allowed it
  p_start_needs_ready_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> $past(ready));

  // R7: bit requests and completion only follow a bit boundary
  p_ready_on_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    bit_ready |-> $past(boundary_evt));
  p_done_on_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(boundary_evt));

  // R3: success drops priority with a fresh idle count
  p_lo_after_done_r3: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (lo_pri && idle_cnt == '0));

  // R8: loss reported only after a sampled zero
  p_loss_needs_zero_r8: assert property (@(posedge clk) disable iff (rst)
    frame_collided |-> ($past(sample_evt) && !$past(cts)));

  // R9: a loss restores high priority
  p_hi_after_loss_r9: assert property (@(posedge clk) disable iff (rst)
    frame_collided |-> !lo_pri);
endmodule

// File: tb/hdlc_bus_arbiter_tb.sv
`timescale 1ns/1ps
module hdlc_bus_arbiter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, sample_late = 1'b0, frame_req = 1'b0;
  logic tx_bit = 1'b1, last_bit = 1'b0;
  logic other = 1'b1;
  logic cts;
  logic txd, bit_ready, frame_done, frame_collided;

  always #2.5 clk = ~clk;

  assign cts = txd & other;

  hdlc_bus_arbiter u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sample_late(sample_late),
    .frame_req(frame_req), .tx_bit(tx_bit), .last_bit(last_bit), .cts(cts),
    .txd(txd), .bit_ready(bit_ready), .frame_done(frame_done),
    .frame_collided(frame_collided)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] pat = 16'b0000_0000_0011_0101;

  int st [0:3];
  int ek [0:3];
  int ee [0:3];
  int natt;
  int rel_bad;
  int txd_bad;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; tick_en = 1'b0; frame_req = 1'b0; other = 1'b1;
    tx_bit = 1'b1; last_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  // one run: zb = bit with other station low on phases in zmask
  task automatic run_case(input bit late, input int len, input int nfr,
                          input int zb, input logic [3:0] zmask, input int reqbit);
    int idx, ok_cnt, c, bitn, ph;
    bit in_frame;
    do_reset();
    sample_late = late;
    idx = 0; ok_cnt = 0; natt = 0; in_frame = 0; rel_bad = 0; txd_bad = 0;
    for (int i = 0; i < 4; i++) begin st[i] = -1; ek[i] = 0; ee[i] = -1; end
    for (c = 0; c < 800 && ok_cnt < nfr && natt < 4; c++) begin
      bitn = c / 4; ph = c % 4;
      tick_en   = 1'b1;
      other     = !((bitn == zb) && zmask[ph]);
      frame_req = (ok_cnt < nfr) && (bitn >= reqbit);
      tx_bit    = (idx < len) ? pat[idx] : 1'b1;
      last_bit  = (idx == len - 1);
      @(posedge clk); #1;
      if (bit_ready) begin
        if (idx == 0) begin st[natt] = bitn; in_frame = 1; end
        if (idx < len && txd !== pat[idx]) txd_bad++;
        idx++;
      end
      if (frame_done || frame_collided) begin
        ek[natt] = frame_done ? 1 : 2;
        ee[natt] = c;
        natt++;
        idx = 0;
        in_frame = 0;
        if (frame_done) ok_cnt++;
      end
      if (!in_frame && txd !== 1'b1) rel_bad++;
    end
    tick_en = 1'b0;
  endtask

  initial begin
    int s;
    // R1 reset state
    @(posedge clk); #1;
    repeat (2) @(posedge clk);
    #1;
    check(txd === 1'b1, "R1 txd in reset", txd, 1);
    check({bit_ready, frame_done, frame_collided} === 3'b000, "R1 pulses in reset",
          {bit_ready, frame_done, frame_collided}, 0);
    rst = 1'b0; tick_en = 1'b0;
    @(posedge clk); #1;
    check(txd === 1'b1 && !bit_ready && !frame_done && !frame_collided,
          "R1 state after reset", txd, 1);

    // R2 R3 R7: frame length sweep, two frames on an idle line
    for (int late = 0; late < 2; late++) begin
      for (int len = 1; len <= 6; len++) begin
        run_case(late[0], len, 2, -1, 4'h0, 0);
        check(st[0] == 8, "R2 first start bit", st[0], 8);
        check(ek[0] == 1 && ee[0] == 4 * (8 + len), "R7 done edge", ee[0], 4 * (8 + len));
        s = 8 + len + 10;
        check(st[1] == s, "R3 low priority start", st[1], s);
        check(ek[1] == 1 && ee[1] == 4 * (s + len), "R7 second done edge", ee[1], 4 * (s + len));
        check(txd_bad == 0, "R7 txd follows framer bits", txd_bad, 0);
        check(rel_bad == 0, "R7 released between frames", rel_bad, 0);
      end
    end

    // R4: full-bit zero in each of bits 0..7
    for (int late = 0; late < 2; late++) begin
      for (int z = 0; z < 8; z++) begin
        run_case(late[0], 3, 1, z, 4'hF, 0);
        check(st[0] == z + 9, "R4 zero restarts idle count", st[0], z + 9);
      end
    end

    // R6: zero on a single tick
    for (int late = 0; late < 2; late++) begin
      run_case(late[0], 3, 1, 5, 4'b1000, 0);
      check(st[0] == (late ? 14 : 8), "R6 zero on tick 3 only", st[0], late ? 14 : 8);
      run_case(late[0], 3, 1, 5, 4'b0100, 0);
      check(st[0] == (late ? 8 : 14), "R6 zero on tick 2 only", st[0], late ? 8 : 14);
      run_case(late[0], 3, 1, 5, 4'b0011, 0);
      check(st[0] == 8, "R6 zero on ticks 0-1 ignored", st[0], 8);
    end

    // R5: long idle before request
    for (int late = 0; late < 2; late++) begin
      run_case(late[0], 2, 1, -1, 4'h0, 20);
      check(st[0] == 20, "R5 start after 20 idle bits", st[0], 20);
      run_case(late[0], 2, 1, -1, 4'h0, 37);
      check(st[0] == 37, "R5 start after 37 idle bits", st[0], 37);
    end

    // R8 R9 R10: other station low for one bit inside frame 0 or frame 1
    for (int late = 0; late < 2; late++) begin
      for (int fr = 0; fr < 2; fr++) begin
        for (int k = 0; k < 6; k++) begin
          s = (fr == 0) ? 8 : 24;
          run_case(late[0], 6, 2, s + k, 4'hF, 0);
          check(st[fr] == s, "R9 attempt start", st[fr], s);
          if (pat[k]) begin
            check(ek[fr] == 2, "R8 collision reported", ek[fr], 2);
            check(ee[fr] == 4 * (s + k) + 2 + late, "R8 collision edge", ee[fr],
                  4 * (s + k) + 2 + late);
            check(st[fr + 1] == s + k + 9, "R9 retry after 8 ones", st[fr + 1], s + k + 9);
            check(ek[fr + 1] == 1 && ee[fr + 1] == 4 * (s + k + 15), "R8 retry completes",
                  ee[fr + 1], 4 * (s + k + 15));
            check(rel_bad == 0, "R8 txd released after loss", rel_bad, 0);
          end else begin
            check(ek[fr] == 1 && ee[fr] == 4 * (s + 6), "R10 zero on zero completes",
                  ee[fr], 4 * (s + 6));
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule